// File: doc/BRIEF.md
# ADC Power-Up Reset and Self-Check Sequencer

This block brings a multi-channel delta-sigma converter out of power-up and proves that it came out clean. On a start pulse it resynchronises the converter's serial port, asks the converter for a system reset, and waits at fixed intervals for the reset-valid flag. It then clears the reset request and reads the configuration register back twice to confirm that the flag has dropped. Last, it reads the offset and gain calibration registers of all four physical channels and compares each one with its power-on default.

All traffic goes through an external byte-wide serial engine, one byte at a time, over two valid/ready streams. The request stream carries the byte to shift out. The response stream returns the byte shifted in during that transfer. The request is held stable while `req_valid` is high and `req_ready` is low, and it may not change until the handshake. The block keeps only one transfer in flight. It raises `rsp_ready` only after its request has been accepted, and it raises `req_valid` again only after the response has been taken. The engine may stall either stream for any number of cycles.

The sequence stops at the first check that fails. The result is given as pass or fail with a one-hot error code, and it is held until the next start.

Top module: `adc_rstchk_top`

## Requirements
- R1: After an accepted start, the first 16 request bytes are fifteen 0xFF followed by one 0xFE, each sent as a single byte.
- R2: A register access is four request bytes: a command byte, then 3 data bytes with the most significant byte first. In the command byte, bit 3 is 1 for a read and 0 for a write. Bits 2:0 select the register: 3 = configuration, 1 = offset, 2 = gain. Bits 5:4 carry the physical channel. On a read, the data bytes sent are 0x00, and the 24-bit value is the three response bytes that follow the command byte, MSB first.
- R3: After the preamble, the block writes the configuration register with 0x000080 (reset-system bit, bit 7 of the low byte).
- R4: Every configuration poll is preceded by an idle gap of at least PAUSE_CYCLES clocks on the request stream. A poll whose low byte has bit 6 (0x40) set ends polling. If none of 8 polls shows that bit, the block fails with error code 4'b0001 and issues no further requests.
- R5: Once bit 6 is seen, the block writes 0x000000 to the configuration register and then reads it twice. Only the second read is checked. A nonzero low byte on that read fails with 4'b0010.
- R6: The offset registers of channels 0 to 3 are read in order and must each be 0x000000. The first mismatch fails with 4'b0100, and no further requests are issued.
- R7: The gain registers of channels 0 to 3 are then read in order and must each be 0x400000. The first mismatch fails with 4'b1000.
- R8: When every check succeeds, `pass` and `done` are 1, `fail` is 0 and `err_code` is 0.
- R9: `done`, `pass`, `fail` and `err_code` are 0 after reset. They hold their values until the next accepted start. A start pulse while a run is in progress is ignored.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_byte` stay unchanged. `req_valid` and `rsp_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| req_valid | output | 1 | Request byte available to the serial engine |
| req_ready | input | 1 | Serial engine accepts the request byte |
| req_byte | output | 8 | Byte to shift out |
| rsp_valid | input | 1 | Serial engine offers the byte shifted in |
| rsp_ready | output | 1 | Sequencer accepts the response byte |
| rsp_byte | input | 8 | Byte shifted in during the transfer |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | All checks succeeded |
| fail | output | 1 | A check failed |
| err_code | output | 4 | One-hot cause: bit0 timeout, bit1 flag not cleared, bit2 offset, bit3 gain |

## Verification
Any slip in the sequencer's step, its byte index or its channel counter shows up at once on the request stream. The wrong command or data byte appears at the very next handshake, so the scoreboard compares every request byte in order against the one predicted from the requirements. A poll counter that is off by one shows up as a ninth poll or as an early timeout, one frame after the eighth poll completes. A wrong comparison shows up as a wrong or missing error code when `done` rises. The pause timer is checked by timing the idle gap before each poll.

// File: rtl/adc_rstchk_pkg.sv
package adc_rstchk_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_RSTW, S_PAUSE, S_POLL, S_CLRW, S_RB1, S_RB2, S_OFF, S_GAIN
  } seq_state_e;

  typedef enum logic [1:0] { F_IDLE, F_SEND, F_WAIT } frm_state_e;

  localparam int ERR_W       = 4;
  localparam int ERR_TIMEOUT = 0;
  localparam int ERR_NOCLR   = 1;
  localparam int ERR_OFFSET  = 2;
  localparam int ERR_GAIN    = 3;
endpackage

// File: rtl/adc_rstchk_timer.sv
module adc_rstchk_timer #(
  parameter int LIMIT = 6250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expired)  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));

  assert_expire_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(run));
endmodule

// File: rtl/adc_rstchk_framer.sv
module adc_rstchk_framer
  import adc_rstchk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        single,
  input  logic [7:0]  hdr,
  input  logic [23:0] wdata,
  output logic        fdone,
  output logic [23:0] rdata,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [7:0]  req_byte,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_byte
);
  frm_state_e  st;
  logic [31:0] sh;
  logic [1:0]  left;

  assign req_valid = (st == F_SEND);
  assign req_byte  = sh[31:24];
  assign rsp_ready = (st == F_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= F_IDLE; sh <= '0; left <= '0; fdone <= 1'b0; rdata <= '0;
    end else begin
      fdone <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          sh   <= {hdr, wdata};
          left <= single ? 2'd0 : 2'd3;
          st   <= F_SEND;
        end
        F_SEND: if (req_ready) st <= F_WAIT;
        F_WAIT: if (rsp_valid) begin
          rdata <= {rdata[15:0], rsp_byte};
          sh    <= {sh[23:0], 8'h00};
          if (left == 2'd0) begin
            fdone <= 1'b1;
            st    <= F_IDLE;
          end else begin
            left <= left - 1'b1;
            st   <= F_SEND;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_byte)));
  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));
endmodule

// File: rtl/adc_rstchk_top.sv
module adc_rstchk_top
  import adc_rstchk_pkg::*;
#(
  parameter int        PAUSE_CYCLES = 6250000,
  parameter int        POLLS        = 8,
  parameter int        CH_N         = 4,
  parameter logic [7:0] RD_FLAG     = 8'h08,
  parameter logic [7:0] SEL_CFG     = 8'h03,
  parameter logic [7:0] SEL_OFF     = 8'h01,
  parameter logic [7:0] SEL_GAIN    = 8'h02,
  parameter int        CH_SHIFT     = 4,
  parameter logic [23:0] OFF_DEF    = 24'h000000,
  parameter logic [23:0] GAIN_DEF   = 24'h400000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [7:0]       req_byte,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [7:0]       rsp_byte,
  output logic             done,
  output logic             pass,
  output logic             fail,
  output logic [ERR_W-1:0] err_code
);
  localparam int PW = $clog2(POLLS + 1);
  localparam int CHW = (CH_N > 1) ? $clog2(CH_N) : 1;
  localparam int PRE_N = 16;

  seq_state_e     st;
  logic           launched, fr_go, fr_single, fr_done, tmr_exp;
  logic [7:0]     fr_hdr;
  logic [23:0]    fr_wdata, fr_rdata;
  logic [3:0]     pre_cnt;
  logic [PW-1:0]  poll_cnt;
  logic [CHW-1:0] ch;

  always_comb begin
    fr_single = 1'b0;
    fr_hdr    = 8'h00;
    fr_wdata  = 24'h0;
    case (st)
      S_PRE: begin
        fr_single = 1'b1;
        fr_hdr    = (pre_cnt == 4'(PRE_N - 1)) ? 8'hFE : 8'hFF;
      end
      S_RSTW:               begin fr_hdr = SEL_CFG; fr_wdata = 24'h000080; end
      S_CLRW:               fr_hdr = SEL_CFG;
      S_POLL, S_RB1, S_RB2: fr_hdr = RD_FLAG | SEL_CFG;
      S_OFF:  fr_hdr = RD_FLAG | SEL_OFF  | (8'(ch) << CH_SHIFT);
      S_GAIN: fr_hdr = RD_FLAG | SEL_GAIN | (8'(ch) << CH_SHIFT);
      default: ;
    endcase
  end

  assign fr_go = !launched && (st != S_IDLE) && (st != S_PAUSE);

  adc_rstchk_framer u_frm (
    .clk(clk), .rst_n(rst_n), .go(fr_go), .single(fr_single), .hdr(fr_hdr),
    .wdata(fr_wdata), .fdone(fr_done), .rdata(fr_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_byte(req_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte)
  );

  adc_rstchk_timer #(.LIMIT(PAUSE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(st == S_PAUSE), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; launched <= 1'b0; pre_cnt <= '0; poll_cnt <= '0; ch <= '0;
      done <= 1'b0; pass <= 1'b0; fail <= 1'b0; err_code <= '0;
    end else begin
      if (fr_go) launched <= 1'b1;
      if (fr_done) launched <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0; pass <= 1'b0; fail <= 1'b0; err_code <= '0;
          pre_cnt <= '0; poll_cnt <= '0; ch <= '0;
          st <= S_PRE;
        end
        S_PRE: if (fr_done) begin
          if (pre_cnt == 4'(PRE_N - 1)) st <= S_RSTW;
          else pre_cnt <= pre_cnt + 1'b1;
        end
        S_RSTW: if (fr_done) st <= S_PAUSE;
        S_PAUSE: if (tmr_exp) begin
          poll_cnt <= poll_cnt + 1'b1;
          st <= S_POLL;
        end
        S_POLL: if (fr_done) begin
          if (fr_rdata[6]) st <= S_CLRW;
          else if (poll_cnt == PW'(POLLS)) begin
            fail <= 1'b1; done <= 1'b1; err_code[ERR_TIMEOUT] <= 1'b1; st <= S_IDLE;
          end else st <= S_PAUSE;
        end
        S_CLRW: if (fr_done) st <= S_RB1;
        S_RB1:  if (fr_done) st <= S_RB2;
        S_RB2: if (fr_done) begin
          if (fr_rdata[7:0] != 8'h00) begin
            fail <= 1'b1; done <= 1'b1; err_code[ERR_NOCLR] <= 1'b1; st <= S_IDLE;
          end else begin
            ch <= '0; st <= S_OFF;
          end
        end
        S_OFF: if (fr_done) begin
          if (fr_rdata != OFF_DEF) begin
            fail <= 1'b1; done <= 1'b1; err_code[ERR_OFFSET] <= 1'b1; st <= S_IDLE;
          end else if (ch == CHW'(CH_N - 1)) begin
            ch <= '0; st <= S_GAIN;
          end else ch <= ch + 1'b1;
        end
        S_GAIN: if (fr_done) begin
          if (fr_rdata != GAIN_DEF) begin
            fail <= 1'b1; done <= 1'b1; err_code[ERR_GAIN] <= 1'b1; st <= S_IDLE;
          end else if (ch == CHW'(CH_N - 1)) begin
            pass <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else ch <= ch + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_fail_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> ($countones(err_code) == 1));
  assert_pass_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (!fail && err_code == '0 && done));
  assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= PW'(POLLS));
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(err_code) && $stable(pass) && done));
  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !req_valid);
endmodule

// File: tb/adc_rstchk_tb.sv
module adc_rstchk_top_tb_top;
  localparam int PAUSE = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic req_valid, req_ready = 1'b0, rsp_valid = 1'b0, rsp_ready;
  logic [7:0] req_byte, rsp_byte = 8'h00;
  logic done, pass, fail;
  logic [3:0] err_code;

  always #4 clk = ~clk;

  adc_rstchk_top #(.PAUSE_CYCLES(PAUSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_byte(req_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
    .done(done), .pass(pass), .fail(fail), .err_code(err_code)
  );

  typedef struct { logic [7:0] rq; logic [7:0] rs; bit pz; string tag; } item_t;
  item_t exq[$];
  int checks = 0, fails = 0, cyc = 0, last_rsp = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] rq, input logic [7:0] rs, input bit pz, input string tag);
    item_t it;
    it.rq = rq; it.rs = rs; it.pz = pz; it.tag = tag;
    exq.push_back(it);
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [23:0] wd, input logic [23:0] rd,
                       input bit pz, input string tag);
    push(cmd, 8'h00, pz, tag);
    push(wd[23:16], rd[23:16], 1'b0, tag);
    push(wd[15:8],  rd[15:8],  1'b0, tag);
    push(wd[7:0],   rd[7:0],   1'b0, tag);
  endtask

  task automatic preamble_and_reset();
    for (int i = 0; i < 15; i++) push(8'hFF, 8'h00, 1'b0, "R1");
    push(8'hFE, 8'h00, 1'b0, "R1");
    frame(8'h03, 24'h000080, 24'h0, 1'b0, "R3");
  endtask

  // Monitor / responder: pops expected request bytes and returns scripted responses
  initial begin : monitor
    int bp = 0;
    forever begin
      @(negedge clk);
      bp++;
      req_ready = (bp % 3) != 0;
      if (req_ready && req_valid) begin
        item_t it;
        if (exq.size() == 0) begin
          chk(1'b0, "R4 unexpected request", req_byte, 0);
          it.rs = 8'h00; it.pz = 1'b0;
        end else begin
          it = exq.pop_front();
          chk(req_byte == it.rq, it.tag, req_byte, it.rq);
          if (it.pz) chk((cyc - last_rsp) >= PAUSE, "R4 pause gap", cyc - last_rsp, PAUSE);
        end
        @(negedge clk);
        req_ready = 1'b0;
        if (bp % 2 == 0) @(negedge clk);
        rsp_valid = 1'b1; rsp_byte = it.rs;
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
        last_rsp = cyc;
      end
    end
  end

  task automatic run_and_wait(input bit poke_busy);
    int w = 0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    if (poke_busy) begin
      repeat (40) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done && w < 20000) begin @(negedge clk); w++; end
    if (w >= 20000) chk(1'b0, "watchdog", w, 0);
    repeat (10) @(negedge clk);
    chk(exq.size() == 0, "R2 all requests seen", exq.size(), 0);
  endtask

  task automatic check_result(input bit ep, input logic [3:0] ee, input string tag);
    chk(done == 1'b1, tag, done, 1);
    chk(pass == ep, tag, pass, ep);
    chk(fail == !ep, tag, fail, !ep);
    chk(err_code == ee, tag, err_code, ee);
  endtask

  task automatic good_tail(input int bad_off, input int bad_gain);
    frame(8'h03, 24'h0, 24'h0, 1'b0, "R5");
    frame(8'h0B, 24'h0, 24'h000040, 1'b0, "R5");
    frame(8'h0B, 24'h0, 24'h000000, 1'b0, "R5");
    for (int c = 0; c < 4; c++) begin
      frame(8'h09 | 8'(c << 4), 24'h0, (c == bad_off) ? 24'h000100 : 24'h0, 1'b0, "R6");
      if (c == bad_off) return;
    end
    for (int c = 0; c < 4; c++) begin
      frame(8'h0A | 8'(c << 4), 24'h0, (c == bad_gain) ? 24'h400001 : 24'h400000, 1'b0, "R7");
      if (c == bad_gain) return;
    end
  endtask

  initial begin : driver
    repeat (4) @(negedge clk);
    chk(done == 0 && pass == 0 && fail == 0 && err_code == 0, "R9 reset outputs",
        {done, pass, fail, err_code}, 0);
    chk(req_valid == 0, "R10 reset request idle", req_valid, 0);
    rst_n = 1'b1;

    // Pass run, valid on third poll, busy start poke
    preamble_and_reset();
    frame(8'h0B, 24'h0, 24'h000000, 1'b1, "R4");
    frame(8'h0B, 24'h0, 24'h000080, 1'b1, "R4");
    frame(8'h0B, 24'h0, 24'h0000C0, 1'b1, "R4");
    good_tail(9, 9);
    run_and_wait(1'b1);
    check_result(1'b1, 4'b0000, "R8 pass");
    repeat (30) @(negedge clk);
    check_result(1'b1, 4'b0000, "R9 held");

    // Timeout run
    preamble_and_reset();
    for (int p = 0; p < 8; p++) frame(8'h0B, 24'h0, 24'hFFFFBF, 1'b1, "R4");
    run_and_wait(1'b0);
    check_result(1'b0, 4'b0001, "R4 timeout");

    // Flag not cleared on second readback
    preamble_and_reset();
    frame(8'h0B, 24'h0, 24'h000040, 1'b1, "R4");
    frame(8'h03, 24'h0, 24'h0, 1'b0, "R5");
    frame(8'h0B, 24'h0, 24'h000040, 1'b0, "R5");
    frame(8'h0B, 24'h0, 24'h000040, 1'b0, "R5");
    run_and_wait(1'b0);
    check_result(1'b0, 4'b0010, "R5 not cleared");

    // Offset mismatch on channel 2
    preamble_and_reset();
    frame(8'h0B, 24'h0, 24'h000040, 1'b1, "R4");
    good_tail(2, 9);
    run_and_wait(1'b0);
    check_result(1'b0, 4'b0100, "R6 offset");

    // Gain mismatch on channel 3
    preamble_and_reset();
    frame(8'h0B, 24'h0, 24'h000040, 1'b1, "R4");
    good_tail(9, 3);
    run_and_wait(1'b0);
    check_result(1'b0, 4'b1000, "R7 gain");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule